// File: doc/BRIEF.md
# Pattern-Memory Bank and Mirroring Selector

This block forms the upper pattern-memory address bits (A19..A10) and the nametable page-select line for a multicart cartridge mapper built around an inner bank-switching controller. For each video-side access it either passes the inner controller's 1 KiB bank number through, or replaces the 8 KiB-granular part of the address with a cartridge-level 8 KiB bank register while the video address bits A12..A10 flow straight through. The A17 bit can be pinned by the outer configuration so that a game sees a 128 KiB window. The two highest bits come directly from outer configuration fields.

The nametable page line is chosen from three sources: the inner controller's mirroring register (vertical or horizontal), an optional single-screen extension of that register, or bit 4 of the inner controller's PRG bank register R6. The last source lets the 32 KiB switched-PRG game mode select a single screen. The block is purely combinational. The inner controller's registers and the scanline counter lie outside it.

Top module: `chr_mirror_sel`

## Requirements
- R1: With `cart8k_mode`=0, outputs A16..A10 (`chr_addr[6:0]`) equal `inner_bank[6:0]` for any video address.
- R2: With `cart8k_mode`=1, A16..A13 (`chr_addr[6:3]`) equal `cart8k_bank[3:0]` and A12..A10 (`chr_addr[2:0]`) equal `ppu_addr[12:10]`. `inner_bank[6:0]` has no effect.
- R3: A17 (`chr_addr[7]`) equals `outer_a17` when `a17_pin`=1 and `inner_bank[7]` when `a17_pin`=0. This holds in both CHR modes.
- R4: With `SWAP_HI`=0, A19 (`chr_addr[9]`) equals `outer_hi[1]` and A18 (`chr_addr[8]`) equals `outer_hi[0]`. With `SWAP_HI`=1, the two are exchanged.
- R5: With `mirror_from_prg`=0 and `single_en`=0, `ciram_a10` equals `ppu_addr[10]` when `mirror_reg[0]`=0 (vertical) and `ppu_addr[11]` when `mirror_reg[0]`=1 (horizontal). `mirror_reg[1]` is then ignored.
- R6: With `mirror_from_prg`=0, `single_en`=1 and `mirror_reg[1]`=1, `ciram_a10` is held at `mirror_reg[0]` (single screen). With `mirror_reg[1]`=0, R5's rule applies.
- R7: With `mirror_from_prg`=1, `ciram_a10` equals `r6_bit4` for every video address and every mirroring register value.
- R8: The address outputs do not depend on the mirroring inputs, and `ciram_a10` does not depend on the bank inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ppu_addr | input | 14 | Video-side address of the current access |
| inner_bank | input | 8 | Inner controller's 1 KiB bank number (A17..A10) for this access |
| cart8k_bank | input | 4 | Cartridge 8 KiB bank number (A16..A13) |
| cart8k_mode | input | 1 | 1 selects the 8 KiB cartridge bank |
| a17_pin | input | 1 | 1 takes A17 from `outer_a17` |
| outer_a17 | input | 1 | Outer A17 value |
| outer_hi | input | 2 | Outer bits for A19/A18 |
| mirror_reg | input | 2 | Inner controller mirroring register, bit 0 V/H, bit 1 single-screen |
| single_en | input | 1 | Enables the single-screen use of `mirror_reg[1]` |
| mirror_from_prg | input | 1 | 1 takes the nametable page from `r6_bit4` |
| r6_bit4 | input | 1 | Bit 4 of the inner PRG bank register R6 |
| chr_addr | output | 10 | Pattern address bits A19..A10 |
| ciram_a10 | output | 1 | Nametable page-select line |

## Verification
The assertions are immediate checks evaluated in the same combinational process that forms each output. They assume only that the inputs are two-state and settled, and they need no history. The bench changes inputs on one clock edge and samples halfway through the next cycle, so every check sees settled values. The random sweep covers every combination of the mode controls together with random bank and address values. A second instance with the pair swapped covers the other board wiring.

// File: rtl/chr_mir_pkg.sv
package chr_mir_pkg;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORIZ  = 2'd1,
    MIR_PAGE0  = 2'd2,
    MIR_PAGE1  = 2'd3
  } mir_kind_e;

  // Decode the inner mirroring register into a layout kind.
  function automatic mir_kind_e mir_decode(input logic [1:0] mreg, input logic single_ok);
    if (single_ok && mreg[1])
      return mreg[0] ? MIR_PAGE1 : MIR_PAGE0;
    return mreg[0] ? MIR_HORIZ : MIR_VERT;
  endfunction

  // Nametable page line for a layout kind and a video address.
  function automatic logic mir_page(input mir_kind_e kind, input logic a10, input logic a11);
    case (kind)
      MIR_VERT:  return a10;
      MIR_HORIZ: return a11;
      MIR_PAGE0: return 1'b0;
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/chrsel_low_bank.sv
module chrsel_low_bank #(
  parameter int INNER_W = 8,
  parameter int PAGE_W  = 3
) (
  input  logic [PAGE_W-1:0]           ppu_page,
  input  logic [INNER_W-1:0]          inner_bank,
  input  logic [INNER_W-2-PAGE_W:0]   cart_bank,
  input  logic                        cart_mode,
  output logic [INNER_W-2:0]          low_bits,
  output logic                        inner_a17
);
  localparam int LOW_W  = INNER_W - 1;
  localparam int CART_W = LOW_W - PAGE_W;

  function automatic logic [LOW_W-1:0] pick_low(
    input logic              mode8k,
    input logic [CART_W-1:0] cbank,
    input logic [PAGE_W-1:0] page,
    input logic [LOW_W-1:0]  ibank
  );
    return mode8k ? {cbank, page} : ibank;
  endfunction

  always_comb begin
    low_bits  = pick_low(cart_mode, cart_bank, ppu_page, inner_bank[LOW_W-1:0]);
    inner_a17 = inner_bank[INNER_W-1];

    if (cart_mode) begin
      p_page_pass_r2: assert (low_bits[PAGE_W-1:0] == ppu_page);
      p_cart_bank_r2: assert (low_bits[LOW_W-1:PAGE_W] == cart_bank);
    end else begin
      p_inner_pass_r1: assert ((low_bits ^ inner_bank[LOW_W-1:0]) == '0);
    end
  end
endmodule

// File: rtl/chrsel_high_merge.sv
module chrsel_high_merge #(
  parameter bit SWAP_HI = 1'b0
) (
  input  logic       inner_a17,
  input  logic       a17_pin,
  input  logic       outer_a17,
  input  logic [1:0] outer_hi,
  output logic [2:0] high_bits   // {A19, A18, A17}
);
  logic [1:0] hi_pair;

  generate
    if (SWAP_HI) begin : g_swapped
      assign hi_pair = {outer_hi[0], outer_hi[1]};
    end else begin : g_straight
      assign hi_pair = outer_hi;
    end
  endgenerate

  always_comb begin
    high_bits = {hi_pair, (a17_pin ? outer_a17 : inner_a17)};

    if (a17_pin) begin
      p_a17_outer_r3: assert (high_bits[0] == outer_a17);
    end else begin
      p_a17_inner_r3: assert (high_bits[0] == inner_a17);
    end
    p_hi_parity_r4: assert ((high_bits[2] ^ high_bits[1]) == (outer_hi[1] ^ outer_hi[0]));
  end
endmodule

// File: rtl/chrsel_mirror.sv
module chrsel_mirror
  import chr_mir_pkg::*;
(
  input  logic       ppu_a10,
  input  logic       ppu_a11,
  input  logic [1:0] mirror_reg,
  input  logic       single_en,
  input  logic       mirror_from_prg,
  input  logic       r6_bit4,
  output logic       ciram_a10,
  output mir_kind_e  mir_kind
);
  always_comb begin
    mir_kind  = mir_decode(mirror_reg, single_en);
    ciram_a10 = mirror_from_prg ? r6_bit4 : mir_page(mir_kind, ppu_a10, ppu_a11);

    if (mirror_from_prg) begin
      p_prg_page_r7: assert (ciram_a10 == r6_bit4);
    end else if (single_en && mirror_reg[1]) begin
      p_single_r6: assert (ciram_a10 == mirror_reg[0]);
    end else if (mirror_reg[0]) begin
      p_horiz_r5: assert (ciram_a10 == ppu_a11);
    end else begin
      p_vert_r5: assert (ciram_a10 == ppu_a10);
    end
  end
endmodule

// File: rtl/chr_mirror_sel.sv
module chr_mirror_sel
  import chr_mir_pkg::*;
#(
  parameter int INNER_W = 8,
  parameter bit SWAP_HI = 1'b0
) (
  input  logic [13:0]          ppu_addr,
  input  logic [INNER_W-1:0]   inner_bank,
  input  logic [INNER_W-5:0]   cart8k_bank,
  input  logic                 cart8k_mode,
  input  logic                 a17_pin,
  input  logic                 outer_a17,
  input  logic [1:0]           outer_hi,
  input  logic [1:0]           mirror_reg,
  input  logic                 single_en,
  input  logic                 mirror_from_prg,
  input  logic                 r6_bit4,
  output logic [INNER_W+1:0]   chr_addr,
  output logic                 ciram_a10
);
  localparam int PAGE_W = 3;
  localparam int LOW_W  = INNER_W - 1;

  logic [LOW_W-1:0] low_bits;
  logic             inner_a17;
  logic [2:0]       high_bits;
  mir_kind_e        mir_kind;

  chrsel_low_bank #(.INNER_W(INNER_W), .PAGE_W(PAGE_W)) u_low (
    .ppu_page   (ppu_addr[10 +: PAGE_W]),
    .inner_bank (inner_bank),
    .cart_bank  (cart8k_bank),
    .cart_mode  (cart8k_mode),
    .low_bits   (low_bits),
    .inner_a17  (inner_a17)
  );

  chrsel_high_merge #(.SWAP_HI(SWAP_HI)) u_high (
    .inner_a17 (inner_a17),
    .a17_pin   (a17_pin),
    .outer_a17 (outer_a17),
    .outer_hi  (outer_hi),
    .high_bits (high_bits)
  );

  chrsel_mirror u_mir (
    .ppu_a10         (ppu_addr[10]),
    .ppu_a11         (ppu_addr[11]),
    .mirror_reg      (mirror_reg),
    .single_en       (single_en),
    .mirror_from_prg (mirror_from_prg),
    .r6_bit4         (r6_bit4),
    .ciram_a10       (ciram_a10),
    .mir_kind        (mir_kind)
  );

  assign chr_addr = {high_bits, low_bits};
endmodule

// File: tb/tb_chr_mirror_sel.sv
module tb_chr_mirror_sel;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [13:0] ppu_addr;
  logic [7:0]  inner_bank;
  logic [3:0]  cart8k_bank;
  logic        cart8k_mode, a17_pin, outer_a17, single_en, mirror_from_prg, r6_bit4;
  logic [1:0]  outer_hi, mirror_reg;
  logic [9:0]  chr_addr, chr_addr_sw;
  logic        ciram_a10, ciram_sw;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  chr_mirror_sel dut (
    .ppu_addr, .inner_bank, .cart8k_bank, .cart8k_mode, .a17_pin, .outer_a17,
    .outer_hi, .mirror_reg, .single_en, .mirror_from_prg, .r6_bit4,
    .chr_addr, .ciram_a10
  );

  chr_mirror_sel #(.SWAP_HI(1'b1)) dut_sw (
    .ppu_addr, .inner_bank, .cart8k_bank, .cart8k_mode, .a17_pin, .outer_a17,
    .outer_hi, .mirror_reg, .single_en, .mirror_from_prg, .r6_bit4,
    .chr_addr(chr_addr_sw), .ciram_a10(ciram_sw)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  function automatic int exp_low();
    if (cart8k_mode) return int'(cart8k_bank) * 8 + int'(ppu_addr[12:10]);
    return int'(inner_bank) % 128;
  endfunction

  function automatic int exp_a17();
    return a17_pin ? int'(outer_a17) : int'(inner_bank) / 128;
  endfunction

  function automatic int exp_page();
    if (mirror_from_prg) return int'(r6_bit4);
    if (single_en && mirror_reg[1]) return int'(mirror_reg[0]);
    return mirror_reg[0] ? int'(ppu_addr[11]) : int'(ppu_addr[10]);
  endfunction

  task automatic settle();
    @(posedge clk);
    #2.5;
  endtask

  task automatic check_all(input string tag);
    check({tag, " R1/R2 low"}, int'(chr_addr[6:0]), exp_low());
    check({tag, " R3 a17"}, int'(chr_addr[7]), exp_a17());
    check({tag, " R4 hi"}, int'(chr_addr[9:8]), int'(outer_hi));
    check({tag, " R4 swapped"}, int'(chr_addr_sw[9:8]), int'(outer_hi[0]) * 2 + int'(outer_hi[1]));
    check({tag, " R5/R6/R7 page"}, int'(ciram_a10), exp_page());
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        done = 1'b1;
      end
    end
  end

  initial begin
    ppu_addr = '0; inner_bank = '0; cart8k_bank = '0; cart8k_mode = 0; a17_pin = 0;
    outer_a17 = 0; outer_hi = '0; mirror_reg = '0; single_en = 0; mirror_from_prg = 0; r6_bit4 = 0;
    settle();
    check("R1 idle address", int'(chr_addr), 0);
    check("R5 idle page", int'(ciram_a10), 0);

    // R2: inner bank has no effect in 8 KiB mode
    cart8k_mode = 1; cart8k_bank = 4'hA; ppu_addr = 14'h1C00; inner_bank = 8'h7F;
    settle();
    check("R2 8k bank", int'(chr_addr[6:0]), 32'h57);
    inner_bank = 8'h00;
    settle();
    check("R2 inner ignored", int'(chr_addr[6:0]), 32'h57);

    // R3: A17 pinned from outer in 8 KiB mode
    a17_pin = 1; outer_a17 = 1;
    settle();
    check("R3 outer a17", int'(chr_addr[7]), 1);

    // R6: bit1 ignored without single_en; honoured with it
    cart8k_mode = 0; a17_pin = 0; mirror_reg = 2'b10; ppu_addr = 14'h0400;
    settle();
    check("R6 bit1 ignored", int'(ciram_a10), 1);
    single_en = 1;
    settle();
    check("R6 page0", int'(ciram_a10), 0);

    // R7: page from PRG bit overrides everything
    mirror_from_prg = 1; r6_bit4 = 1; ppu_addr = 14'h0000;
    settle();
    check("R7 prg page", int'(ciram_a10), 1);

    // R8: address independent of mirroring inputs
    inner_bank = 8'hC3;
    settle();
    check("R8 base", int'(chr_addr[7:0]), 32'hC3);
    mirror_reg = 2'b01; single_en = 0; mirror_from_prg = 0; r6_bit4 = 0;
    settle();
    check("R8 mirror change", int'(chr_addr[7:0]), 32'hC3);
    check("R5 horizontal", int'(ciram_a10), int'(ppu_addr[11]));

    for (int i = 0; i < 20000; i++) begin
      {cart8k_mode, a17_pin, single_en, mirror_from_prg} = 4'(i);
      ppu_addr    = 14'($urandom);
      inner_bank  = 8'($urandom);
      cart8k_bank = 4'($urandom);
      outer_a17   = 1'($urandom);
      outer_hi    = 2'($urandom);
      mirror_reg  = 2'($urandom);
      r6_bit4     = 1'($urandom);
      settle();
      check_all("sweep");
      check("R8 page same on both", int'(ciram_sw), int'(ciram_a10));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule